// File: doc/BRIEF.md
# Offset Calibration and Sleep Controller

This controller chooses the operating state of a charge-counting front end. Its inputs are the level of the serial data line (already synchronised), the offset-corrected sense signal as a signed value in fixed units, a running offset measurement, and a one-second tick. From these it drives an open-drain wake request and decides when to sleep and when to wake. It also runs the offset-calibration cycle. The wake threshold is a full-scale constant divided by a 3-bit code held in an 8-bit mode register. Sense units are chosen so that full scale (3.84 mV) is `FULL_SCALE` = 420 units, which makes every threshold an integer: code 7 gives 60 units and code 1 gives 420.

Calibration is armed by a mode bit. It needs the data line held low and the sense input quiet without a break: first for the sleep qualification window, then for a full calibration hour. When the cycle completes, the running measurement is copied into a signed 8-bit offset register and the arming bits clear themselves. An override bit drops the line condition and the qualification window, so only the quiet condition and the hour count. Any violation restarts the count from zero.

Top module: `ocs_cal_sleep_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0E, the offset register reads 0x00, and wake, sleep and calibration-done are all 0.
- R2: `wake_pull_o` is 1 one cycle after a sample whose magnitude |sense| is strictly greater than 420/code units, for either sign. At or below that value it is 0.
- R3: A write updates mode bits 7:1 (bit 7 override, bit 6 calibrate, bits 5:4 plain storage, bits 3:1 threshold code). Bit 0 always reads 0. A write whose code field is 0 keeps the previous code.
- R4: Sleep asserts once more than `LOW_SECONDS` ticks (that is, 11) have been counted with the line low and the input quiet. Line high or a loud input resets that count.
- R5: Sleep clears in the cycle after the line is seen high.
- R6: With bit 6 set, after `LOW_SECONDS`+1+`CAL_SECONDS` ticks of line low and a quiet input, the offset register takes `offset_meas_i`, bits 7 and 6 clear, and `cal_done_o` pulses for one cycle.
- R7: A line-high cycle or a loud sample during calibration restarts the count. Bit 6 stays set and the offset register is unchanged.
- R8: With bit 7 set, the line level is ignored and calibration completes after `CAL_SECONDS` quiet ticks.
- R9: After a completed calibration, sleep is asserted as long as the line stays low.
- R10: With bit 6 clear, the offset register never changes and `cal_done_o` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised serial data line level |
| tick_i | input | 1 | One-cycle pulse each second |
| sense_i | input | SENSE_W | Signed offset-corrected sense value |
| offset_meas_i | input | 8 | Running two's-complement offset measurement |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| wake_pull_o | output | 1 | 1 = pull the open-drain wake pin low |
| sleep_o | output | 1 | Low-power state |
| cal_done_o | output | 1 | One-cycle pulse at calibration completion |
| mode_o | output | 8 | Mode register contents |
| offset_o | output | 8 | Latched offset register |

## Verification
The bench looks at the threshold edge: a value exactly at 420/code must leave wake released, and a design that compared with greater-or-equal would pull the pin one step too early. It breaks a calibration hour with a short line-high pulse and, in override mode, with a loud burst. A design that paused the count instead of restarting it would latch the offset too soon, and one that cleared the arming bit on abort would never finish. A write with a zero code checks that the threshold keeps its previous code instead of dividing by zero. Sleep entry is checked at exactly the 11th tick, and completion with the line held low is checked to leave the block asleep.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

    typedef struct packed {
        logic       ovr;
        logic       cal;
        logic [1:0] aux;
        logic [2:0] code;
        logic       rsv;
    } mode_t;

    localparam logic [7:0] MODE_RST = 8'h0E;

    // Host write: bit 0 forced to 0, a zero code keeps the old one
    function automatic mode_t mode_write(mode_t cur, logic [7:0] wd);
        mode_t m;
        m      = mode_t'(wd);
        m.rsv  = 1'b0;
        if (wd[3:1] == 3'd0) m.code = cur.code;
        return m;
    endfunction

endpackage

// File: rtl/ocs_level_cmp.sv
module ocs_level_cmp #(
    parameter int SENSE_W    = 16,
    parameter int FULL_SCALE = 420
) (
    input  logic signed [SENSE_W-1:0] sense_i,
    input  logic        [2:0]         code_i,
    output logic                      loud_o
);
    localparam int PW = SENSE_W + 3;
    localparam logic [PW-1:0] FS = PW'(FULL_SCALE);

    logic [SENSE_W-1:0] mag;
    logic [PW-1:0]      prod;

    // |x| > FULL_SCALE/code  <=>  |x|*code > FULL_SCALE (no divider)
    always_comb begin
        mag    = sense_i[SENSE_W-1] ? SENSE_W'(-sense_i) : SENSE_W'(sense_i);
        prod   = PW'(mag) * PW'(code_i);
        loud_o = prod > FS;
    end
endmodule

// File: rtl/ocs_sec_window.sv
module ocs_sec_window #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             reached_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!hold_i)                          cnt_d = '0;
        else if (tick_i && cnt_q < limit_i)   cnt_d = cnt_q + 1'b1;
        reached_o = cnt_q >= limit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> !reached_o || limit_i == '0);
endmodule

// File: rtl/ocs_cal_sleep_ctrl.sv
module ocs_cal_sleep_ctrl
    import ocs_pkg::*;
#(
    parameter int SENSE_W     = 16,
    parameter int FULL_SCALE  = 420,
    parameter int LOW_SECONDS = 10,
    parameter int CAL_SECONDS = 3600
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_i,
    input  logic                      tick_i,
    input  logic signed [SENSE_W-1:0] sense_i,
    input  logic        [7:0]         offset_meas_i,
    input  logic                      mode_we_i,
    input  logic        [7:0]         mode_wdata_i,
    output logic                      wake_pull_o,
    output logic                      sleep_o,
    output logic                      cal_done_o,
    output logic        [7:0]         mode_o,
    output logic        [7:0]         offset_o
);
    localparam int QUAL_TICKS = LOW_SECONDS + 1;
    localparam int CNT_W      = $clog2(CAL_SECONDS + QUAL_TICKS + 1) + 1;
    localparam logic [CNT_W-1:0] LIM_QUAL = CNT_W'(QUAL_TICKS);
    localparam logic [CNT_W-1:0] LIM_OVR  = CNT_W'(CAL_SECONDS);
    localparam logic [CNT_W-1:0] LIM_CAL  = CNT_W'(CAL_SECONDS + QUAL_TICKS);

    typedef struct packed {
        mode_t      mode;
        logic [7:0] ofs;
        logic       wake;
        logic       sleep;
        logic       done;
    } st_t;

    st_t st_d, st_q;

    logic             loud, quiet;
    logic             low_hold, low_reached;
    logic             cal_hold, cal_reached;
    logic [CNT_W-1:0] cal_limit;
    logic             finish;

    ocs_level_cmp #(.SENSE_W(SENSE_W), .FULL_SCALE(FULL_SCALE)) u_cmp (
        .sense_i (sense_i),
        .code_i  (st_q.mode.code),
        .loud_o  (loud)
    );

    assign quiet     = !loud;
    assign low_hold  = !line_i && quiet;
    assign cal_hold  = st_q.mode.cal && quiet && (st_q.mode.ovr || !line_i);
    assign cal_limit = st_q.mode.ovr ? LIM_OVR : LIM_CAL;

    ocs_sec_window #(.CNT_W(CNT_W)) u_low (
        .clk(clk), .rst_n(rst_n), .hold_i(low_hold), .tick_i(tick_i),
        .limit_i(LIM_QUAL), .reached_o(low_reached)
    );

    ocs_sec_window #(.CNT_W(CNT_W)) u_cal (
        .clk(clk), .rst_n(rst_n), .hold_i(cal_hold), .tick_i(tick_i),
        .limit_i(cal_limit), .reached_o(cal_reached)
    );

    assign finish = cal_hold && cal_reached;

    always_comb begin
        st_d      = st_q;
        st_d.wake = loud;
        st_d.done = finish;
        if (mode_we_i) st_d.mode = mode_write(st_q.mode, mode_wdata_i);
        if (finish) begin
            st_d.ofs      = offset_meas_i;
            st_d.mode.cal = 1'b0;
            st_d.mode.ovr = 1'b0;
        end
        if (line_i) st_d.sleep = 1'b0;
        else        st_d.sleep = st_q.sleep || (low_reached && low_hold) || finish;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= mode_t'(MODE_RST);
        end else begin
            st_q       <= st_d;
        end
    end

    assign wake_pull_o = st_q.wake;
    assign sleep_o     = st_q.sleep;
    assign cal_done_o  = st_q.done;
    assign mode_o      = st_q.mode;
    assign offset_o    = st_q.ofs;

    // R3
    mode_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[0] == 1'b0 && mode_o[3:1] != 3'd0);
    // R5
    sleep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(!line_i));
    // R6
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> !mode_o[7] && !mode_o[6]);
    // R10
    done_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> $past(mode_o[6]));
    // R7
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset_o) |-> cal_done_o);
endmodule

// File: tb/sim_ocs_cal_sleep_ctrl.sv
module sim_ocs_cal_sleep_ctrl;
    logic clk = 0;
    logic rst_n = 0;
    logic line = 1, tick = 0, tick_en = 0, we = 0;
    logic signed [15:0] sense = 0;
    logic [7:0] om = 0, wd = 0;
    logic wake, slp, done;
    logic [7:0] mode, ofs;

    int checks = 0, errors = 0, cycles = 0, done_cnt = 0;
    bit finished = 0;

    // reference state
    int m_mode = 8'h0E, m_ofs = 0, m_wake = 0, m_sleep = 0, m_done = 0;
    int lowc = 0, calc = 0;

    always #2.5 clk = ~clk;

    ocs_cal_sleep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .line_i(line), .tick_i(tick), .sense_i(sense),
        .offset_meas_i(om), .mode_we_i(we), .mode_wdata_i(wd),
        .wake_pull_o(wake), .sleep_o(slp), .cal_done_o(done),
        .mode_o(mode), .offset_o(ofs)
    );

    always @(negedge clk) tick <= tick_en ? ~tick : 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 8'h0E; m_ofs = 0; m_wake = 0; m_sleep = 0; m_done = 0;
            lowc = 0; calc = 0;
        end else begin
            int code, s, a, need, nm;
            bit loud, ovr, cal, calok, fin, lowok, lowfull;
            code = (m_mode >> 1) & 7;
            s = sense;
            a = (s < 0) ? -s : s;
            loud = (a * code) > 420;
            ovr = m_mode[7]; cal = m_mode[6];
            need = ovr ? 3600 : 3611;
            calok = cal && !loud && (ovr || !line);
            fin = calok && (calc >= need);
            lowok = !line && !loud;
            lowfull = lowc >= 11;
            nm = m_mode;
            if (we) begin
                nm = wd & 8'hFE;
                if (((wd >> 1) & 7) == 0) nm = (nm & 8'hF1) | (m_mode & 8'h0E);
            end
            if (fin) begin nm = nm & 8'h3F; m_ofs = om; end
            m_sleep = line ? 0 : (m_sleep || (lowfull && lowok) || fin);
            m_mode = nm;
            m_wake = loud;
            m_done = fin;
            if (!lowok) lowc = 0; else if (tick && lowc < 11) lowc++;
            if (!calok) calc = 0; else if (tick && calc < need) calc++;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) if (rst_n && !finished) begin
        cycles++;
        if (done) done_cnt++;
        chk("R2 wake", wake, m_wake);
        chk("R4 sleep", slp, m_sleep);
        chk("R6 done", done, m_done);
        chk("R3 mode", mode, m_mode);
        chk("R6 offset", ofs, m_ofs);
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            finished = 1;
            $finish;
        end
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask
    task automatic ticks(int n);
        int k = 0;
        while (k < n) begin @(negedge clk); if (tick) k++; end
    endtask
    task automatic wr(logic [7:0] v);
        @(negedge clk); we = 1; wd = v;
        @(negedge clk); we = 0;
    endtask

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        // R1
        chk("R1 mode", mode, 8'h0E); chk("R1 offset", ofs, 0);
        chk("R1 wake", wake, 0); chk("R1 sleep", slp, 0); chk("R1 done", done, 0);
        // R2 code 7 -> 60 units
        sense = 61;  cyc(2); chk("R2 pos above", wake, 1);
        sense = -61; cyc(2); chk("R2 neg above", wake, 1);
        sense = 60;  cyc(2); chk("R2 at threshold", wake, 0);
        sense = -60; cyc(2); chk("R2 neg at threshold", wake, 0);
        // R3
        wr(8'h31); cyc(1); chk("R3 zero code kept, bit0 0", mode, 8'h3E);
        wr(8'h02); cyc(1); chk("R3 code 1", mode, 8'h02);
        sense = 420; cyc(2); chk("R2 code1 at 420", wake, 0);
        sense = 421; cyc(2); chk("R2 code1 above", wake, 1);
        sense = 0; wr(8'h0E);
        // R4
        tick_en = 1; line = 0;
        ticks(5); sense = 100; cyc(2); sense = 0;
        ticks(9); chk("R4 restart after loud", slp, 0);
        ticks(3); cyc(2); chk("R4 asleep", slp, 1);
        // R5
        line = 1; cyc(2); chk("R5 wake on line", slp, 0);
        // R10
        line = 0; om = 8'h5A; ticks(3700);
        chk("R10 offset untouched", ofs, 0); chk("R10 no done", done_cnt, 0);
        // R7
        line = 1; wr(8'h4E); om = 8'hFB; line = 0;
        ticks(2000); line = 1; cyc(2); line = 0;
        ticks(3000);
        chk("R7 cal still armed", mode, 8'h4E); chk("R7 offset unchanged", ofs, 0);
        // R6, R9
        ticks(700); cyc(2);
        chk("R6 offset latched", ofs, 8'hFB); chk("R6 bits cleared", mode, 8'h0E);
        chk("R6 one pulse", done_cnt, 1); chk("R9 asleep after cal", slp, 1);
        // R8
        line = 1; wr(8'hCE); om = 8'h22;
        ticks(3000); sense = -200; cyc(2); sense = 0;
        chk("R7 override abort", ofs, 8'hFB);
        ticks(3605); cyc(2);
        chk("R8 offset latched", ofs, 8'h22); chk("R8 bits cleared", mode, 8'h0E);
        chk("R8 pulses", done_cnt, 2); chk("R5 line high no sleep", slp, 0);
        tick_en = 0; cyc(4);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule